// File: doc/BRIEF.md
# Nibble-Fold Checksum Sequencer

This block walks a region of a byte-wide memory and reduces it to a 16-bit check value with a nibble-folding update. It is started with a base address, a byte count, a destination address and a write-back flag. Each update consumes a 16-bit word built from two neighbouring bytes. The byte offset steps by one per update, so consecutive words share a byte. An odd count adds one last update, in which the trailing byte sits in the high half and zero fills the low half.

The block drives a plain synchronous memory port. Read data returns one cycle after the read strobe. Every byte is fetched exactly once and kept in a holding register, where it forms the high half of the next word. When write-back is requested, the 16-bit result is stored most significant byte first in two consecutive byte writes. A typical use is sealing a configuration header: the check value is computed over the first 0xF8 bytes and stored at offset 0xFC.

Top module: `nvsum_engine`

## Requirements
- R1: After start, the accumulator is 0xFFFF. A count of zero reads no memory and yields 0xFFFF.
- R2: Each update maps the accumulator p and word v to: (p>>8) ^ (a<<3) ^ (a<<8) ^ b ^ (b<<7) ^ (b<<12), truncated to 16 bits, where d = p^v, a = d[3:0] and b = d[7:4]^a.
- R3: Let E be the count with bit 0 cleared. For i = 0..E-1 the word is {mem[base+i], mem[base+i+1]}, high byte first.
- R4: When count bit 0 is set, one final update uses the word {mem[base+E], 8'h00}.
- R5: Reads are issued singly, with never two strobes in consecutive cycles. No address is read twice per operation. The number of reads is E+1 when E>0, 1 when count is 1, and 0 when count is 0.
- R6: With write-back set, the result high byte is written at dest and then the low byte at dest+1, in consecutive cycles. With write-back clear, no write occurs.
- R7: A start asserted while busy is high is ignored and does not change the result, the reads or the writes.
- R8: done_o is high for exactly one cycle at completion, with busy_o low. busy_o is high from the cycle after an accepted start until completion.
- R9: After reset, busy_o, done_o, mem_rd_o and mem_wr_o are 0 and result_o is 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted only when idle |
| start_addr_i | input | ADDR_W | First byte of the region |
| count_i | input | CNT_W | Region length in bytes |
| dest_addr_i | input | ADDR_W | Destination of the high result byte |
| write_back_i | input | 1 | Store the result after computing |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_rd_o | output | 1 | Read strobe; data is valid in the next cycle |
| mem_rdata_i | input | 8 | Read data |
| mem_wr_o | output | 1 | Write strobe |
| mem_wdata_o | output | 8 | Write data |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 16 | Accumulator / final check value |

## Verification
The hardest situation to reach is a second start request that arrives while a read is still outstanding and carries parameters of its own. The stimulus raises start mid-operation with a different base and count, then confirms that the read total and the result still match the first request. A second hard case is the odd-count tail, which must reuse the held byte with no new read. Directed counts of 0, 1, 2 and 3 cover it, together with randomly drawn odd and even lengths. Reference values come from a bench model of the fold applied to the bench RAM contents.

// File: rtl/nvsum_pkg.sv
package nvsum_pkg;
  localparam logic [15:0] ACC_SEED = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_CAP,
    ST_TAIL,
    ST_WHI,
    ST_WLO
  } seq_state_e;
endpackage

// File: rtl/nvsum_fold.sv
module nvsum_fold (
  input  logic [15:0] prev_i,
  input  logic [15:0] val_i,
  output logic [15:0] next_o
);
  logic [15:0] diff;
  logic [15:0] lo_n;
  logic [15:0] mix_n;

  always_comb begin
    diff   = prev_i ^ val_i;
    lo_n   = {12'h000, diff[3:0]};
    mix_n  = {12'h000, diff[7:4] ^ diff[3:0]};
    next_o = {8'h00, prev_i[15:8]}
           ^ (lo_n << 3) ^ (lo_n << 8)
           ^ mix_n ^ (mix_n << 7) ^ (mix_n << 12);
  end
endmodule

// File: rtl/nvsum_seq.sv
module nvsum_seq
  import nvsum_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] dest_addr_i,
  input  logic              write_back_i,
  input  logic [7:0]        mem_rdata_i,
  input  logic [15:0]       fold_next_i,
  output logic [15:0]       acc_o,
  output logic [15:0]       fold_val_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int REM_W = CNT_W + 1;

  seq_state_e        state_q;
  logic [ADDR_W-1:0] ptr_q, dest_q;
  logic [REM_W-1:0]  remain_q;
  logic              wb_q, odd_q, first_q;
  logic [7:0]        held_q;
  logic [15:0]       acc_q;

  logic [CNT_W-1:0]  even_part;
  logic [REM_W-1:0]  reads_needed;

  always_comb begin
    even_part    = {count_i[CNT_W-1:1], 1'b0};
    reads_needed = (even_part != '0) ? ({1'b0, even_part} + REM_W'(1))
                                     : {{CNT_W{1'b0}}, count_i[0]};
  end

  // tail word pads the low byte with zero
  assign fold_val_o  = (state_q == ST_TAIL) ? {held_q, 8'h00} : {held_q, mem_rdata_i};
  assign acc_o       = acc_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign mem_rd_o    = (state_q == ST_RD);
  assign mem_wr_o    = (state_q == ST_WHI) || (state_q == ST_WLO);
  assign mem_wdata_o = (state_q == ST_WHI) ? acc_q[15:8] : acc_q[7:0];

  always_comb begin
    unique case (state_q)
      ST_WHI:  mem_addr_o = dest_q;
      ST_WLO:  mem_addr_o = dest_q + ADDR_W'(1);
      default: mem_addr_o = ptr_q;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ptr_q    <= '0;
      dest_q   <= '0;
      remain_q <= '0;
      wb_q     <= 1'b0;
      odd_q    <= 1'b0;
      first_q  <= 1'b0;
      held_q   <= '0;
      acc_q    <= ACC_SEED;
      done_o   <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            acc_q    <= ACC_SEED;
            ptr_q    <= start_addr_i;
            dest_q   <= dest_addr_i;
            wb_q     <= write_back_i;
            odd_q    <= count_i[0];
            remain_q <= reads_needed;
            first_q  <= 1'b1;
            if (reads_needed != '0)  state_q <= ST_RD;
            else if (write_back_i)   state_q <= ST_WHI;
            else                     done_o  <= 1'b1;
          end
        end
        ST_RD: state_q <= ST_CAP;
        ST_CAP: begin
          held_q   <= mem_rdata_i;
          first_q  <= 1'b0;
          if (!first_q) acc_q <= fold_next_i;
          ptr_q    <= ptr_q + ADDR_W'(1);
          remain_q <= remain_q - REM_W'(1);
          if (remain_q != REM_W'(1)) state_q <= ST_RD;
          else if (odd_q)            state_q <= ST_TAIL;
          else if (wb_q)             state_q <= ST_WHI;
          else begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        ST_TAIL: begin
          acc_q <= fold_next_i;
          if (wb_q) state_q <= ST_WHI;
          else begin
            state_q <= ST_IDLE;
            done_o  <= 1'b1;
          end
        end
        ST_WHI: state_q <= ST_WLO;
        ST_WLO: begin
          state_q <= ST_IDLE;
          done_o  <= 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_RD_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> !mem_rd_o);  // R5
  AST_RD_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> busy_o);  // R5
  AST_NO_RD_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o));  // R6
  AST_WB_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o && !$past(mem_wr_o)) |=> (mem_wr_o && mem_addr_o == $past(mem_addr_o) + ADDR_W'(1)));  // R6
  AST_ZERO_NO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o && count_i == '0) |=> !mem_rd_o);  // R1
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);  // R8
endmodule

// File: rtl/nvsum_engine.sv
module nvsum_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  count_i,
  input  logic [ADDR_W-1:0] dest_addr_i,
  input  logic              write_back_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_rd_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              mem_wr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [15:0]       result_o
);
  logic [15:0] acc, fold_val, fold_next;

  nvsum_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) seq_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_addr_i (start_addr_i),
    .count_i      (count_i),
    .dest_addr_i  (dest_addr_i),
    .write_back_i (write_back_i),
    .mem_rdata_i  (mem_rdata_i),
    .fold_next_i  (fold_next),
    .acc_o        (acc),
    .fold_val_o   (fold_val),
    .mem_addr_o   (mem_addr_o),
    .mem_rd_o     (mem_rd_o),
    .mem_wr_o     (mem_wr_o),
    .mem_wdata_o  (mem_wdata_o),
    .busy_o       (busy_o),
    .done_o       (done_o)
  );

  nvsum_fold fold_i (
    .prev_i (acc),
    .val_i  (fold_val),
    .next_o (fold_next)
  );

  assign result_o = acc;
endmodule

// File: tb/nvsum_engine_tb_top.sv
module nvsum_engine_tb_top;
  localparam int AW = 8;
  localparam int CW = 9;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic          start = 1'b0;
  logic [AW-1:0] s_addr = '0, d_addr = '0;
  logic [CW-1:0] cnt = '0;
  logic          wb = 1'b0;
  logic [AW-1:0] m_addr;
  logic          m_rd, m_wr, busy, done;
  logic [7:0]    m_rdata, m_wdata;
  logic [15:0]   result;

  logic          fill_we = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [7:0]    fill_data = '0;
  logic [7:0]    ram [256];

  int checks = 0, errors = 0;
  int rd_cnt = 0, wr_cnt = 0, dup_cnt = 0, done_bad = 0;
  int epoch = 1;
  int seen [256];
  logic done_prev = 1'b0;

  nvsum_engine #(.ADDR_W(AW), .CNT_W(CW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .start_addr_i(s_addr),
    .count_i(cnt), .dest_addr_i(d_addr), .write_back_i(wb),
    .mem_addr_o(m_addr), .mem_rd_o(m_rd), .mem_rdata_i(m_rdata),
    .mem_wr_o(m_wr), .mem_wdata_o(m_wdata), .busy_o(busy), .done_o(done),
    .result_o(result)
  );

  // behavioural RAM, one-cycle read latency
  always @(posedge clk) begin
    if (m_rd) m_rdata <= ram[m_addr];
    if (m_wr) ram[m_addr] <= m_wdata;
    else if (fill_we) ram[fill_addr] <= fill_data;
  end

  always @(posedge clk) begin
    if (m_rd) begin
      rd_cnt <= rd_cnt + 1;
      if (seen[m_addr] == epoch) dup_cnt <= dup_cnt + 1;
      seen[m_addr] <= epoch;
    end
    if (m_wr) wr_cnt <= wr_cnt + 1;
    if (done && done_prev) done_bad <= done_bad + 1;
    done_prev <= done;
  end

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
    $finish;
  end

  function automatic logic [15:0] ref_step(logic [15:0] p, logic [15:0] v);
    logic [15:0] d, a, b;
    d = p ^ v;
    a = {12'h0, d[3:0]};
    b = {12'h0, d[7:4]} ^ a;
    return (p >> 8) ^ (a << 3) ^ (a << 8) ^ b ^ (b << 7) ^ (b << 12);
  endfunction

  function automatic logic [15:0] ref_sum(int base, int n);
    logic [15:0] acc;
    int e;
    acc = 16'hFFFF;
    e = n & ~1;
    for (int i = 0; i < e; i++)
      acc = ref_step(acc, {ram[(base + i) % 256], ram[(base + i + 1) % 256]});
    if (n % 2 == 1) acc = ref_step(acc, {ram[(base + e) % 256], 8'h00});
    return acc;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic fill_ram();
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      fill_we = 1'b1; fill_addr = AW'(i); fill_data = 8'($urandom_range(0, 255));
    end
    @(negedge clk);
    fill_we = 1'b0;
  endtask

  // intrude: pulse a second start while busy with other parameters
  task automatic run_op(int base, int n, int dest, bit do_wb, bit intrude, string req);
    int rd0, wr0, dup0, e, exp_rd, waited;
    logic [15:0] exp;
    logic [7:0] old_hi, old_lo;
    bit got;
    epoch++;
    exp = ref_sum(base, n);
    e = n & ~1;
    exp_rd = (e > 0) ? e + 1 : n;
    old_hi = ram[dest % 256];
    old_lo = ram[(dest + 1) % 256];
    @(negedge clk);
    rd0 = rd_cnt; wr0 = wr_cnt; dup0 = dup_cnt;
    start = 1'b1; s_addr = AW'(base); cnt = CW'(n); d_addr = AW'(dest); wb = do_wb;
    @(negedge clk);
    start = 1'b0;
    s_addr = AW'(base + 7); cnt = CW'(n + 3); d_addr = AW'(dest - 20); wb = ~do_wb;
    got = done;
    if (n != 0 || do_wb) check("R8", "busy after start", int'(busy), 1);
    if (intrude && busy) begin
      @(negedge clk);
      check("R7", "busy at intruding start", int'(busy), 1);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      got = done;
    end
    waited = 0;
    while (!got && waited < 2000) begin
      @(negedge clk);
      got = done;
      waited++;
    end
    check(req, "done seen", int'(got), 1);
    check(req, "result", int'(result), int'(exp));
    check("R8", "busy low at done", int'(busy), 0);
    check("R5", "read count", rd_cnt - rd0, exp_rd);
    check("R5", "duplicate reads", dup_cnt - dup0, 0);
    check("R6", "write count", wr_cnt - wr0, do_wb ? 2 : 0);
    if (do_wb) begin
      check("R6", "high byte at dest", int'(ram[dest % 256]), int'(exp[15:8]));
      check("R6", "low byte at dest+1", int'(ram[(dest + 1) % 256]), int'(exp[7:0]));
    end else begin
      check("R6", "dest untouched", int'({ram[dest % 256], ram[(dest + 1) % 256]}),
            int'({old_hi, old_lo}));
    end
    @(negedge clk);
    check("R8", "done single cycle", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    check("R9", "busy at reset", int'(busy), 0);
    check("R9", "done at reset", int'(done), 0);
    check("R9", "rd at reset", int'(m_rd), 0);
    check("R9", "wr at reset", int'(m_wr), 0);
    check("R9", "result at reset", int'(result), 16'hFFFF);
    rst_n = 1'b1;
    fill_ram();

    run_op(10, 0, 240, 1'b0, 1'b0, "R1");
    check("R1", "zero count result", int'(result), 16'hFFFF);
    run_op(20, 0, 242, 1'b1, 1'b0, "R1");
    run_op(30, 1, 244, 1'b0, 1'b0, "R4");
    run_op(31, 2, 244, 1'b0, 1'b0, "R3");
    run_op(32, 3, 246, 1'b1, 1'b0, "R4");
    run_op(0, 8'hF8, 8'hFC, 1'b1, 1'b0, "R2");
    run_op(5, 40, 248, 1'b1, 1'b1, "R7");
    run_op(60, 17, 250, 1'b0, 1'b1, "R7");
    for (int t = 0; t < 24; t++) begin
      int b, n, d;
      b = $urandom_range(0, 120);
      n = $urandom_range(0, 100);
      d = $urandom_range(242, 252);
      run_op(b, n, d, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             (n % 2 == 1) ? "R4" : "R3");
    end
    check("R8", "done wider than one cycle", done_bad, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule